// File: doc/BRIEF.md
# Prescaled Period Timebase

This block turns a 250 MHz system clock into a slower, programmable time base. A prescale divider emits a one-cycle enable every N system cycles, where N is the prescale setting. On each enable, a 16-bit timer steps forward by one. It runs from zero up to one below the programmed period and then returns to zero. Modulators and other consumers can then compare against the timer, or act on the enable. Each timer tick therefore lasts 4 ns times the prescale value. For example, period 12500 with prescale 1 gives a 20 kHz cycle, and period 62500 with prescale 2 gives 2 kHz. With prescale 1, the slowest rate is 250 MHz / 65535, about 3.8 kHz.

The period and prescale inputs are not used directly. They are captured into a pair of registers only at the wrap point, which is the enable cycle on which the timer is at its last value. A running period is therefore never cut short or stretched. The captured values are also brought out, so consumers can see the settings that are currently in force. Several instances can run side by side as independent time bases.

Top module: `tbase_timer`

## Requirements
- R1: While reset is asserted (rst_n low), the timer, the prescale phase, the captured period and the captured prescale are all 0.
- R2: When the captured prescale is 0 or 1, tick_en is high on every system clock cycle. A prescale of 0 is treated as 1.
- R3: When the captured prescale is X > 1, tick_en is high for one cycle out of every X. Consecutive ticks are therefore 4 ns × X apart at 250 MHz.
- R4: The timer keeps its value on cycles where tick_en is low. On a tick cycle where the timer is not at its last value, it advances by exactly one.
- R5: With a captured period P > 0, the timer runs 0, 1, …, P-1. On the tick where it equals P-1, it goes to 0, so it stays below P at all times.
- R6: With a captured period of 0, the timer is held at 0. Every tick then counts as a wrap point.
- R7: cfg_period and cfg_prescale are captured only on a wrap tick, and they appear on period_q / prescale_q on the following cycle. Changes to these inputs at any other time have no effect on the outputs.
- R8: The reset values (period 0, prescale 0) make the first clock edge after reset release a wrap point. That edge captures the inputs, with the timer at 0.
- R9: The full 16-bit range works. Period 65535 makes the timer reach 65534 before it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 250 MHz system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_period | input | 16 | Requested period in ticks, taken at the next wrap |
| cfg_prescale | input | 16 | Requested system cycles per tick, taken at the next wrap (0 acts as 1) |
| timer | output | 16 | Timer value, 0 to period-1 |
| tick_en | output | 1 | One-cycle enable marking each timer step |
| period_q | output | 16 | Period currently in force |
| prescale_q | output | 16 | Prescale currently in force |

## Verification
Two things can fall on the same clock edge. A tick can coincide with the timer's last value, so the wrap back to zero and the capture of new settings happen together. A new prescale then takes effect on that same edge, with no stray tick. The bench provokes this by changing the inputs in the middle of a period, at prescale 0, 1 and above, and with period 0, where every tick is a wrap. A behavioural model predicts the timer, the enable and the captured settings for every cycle. Cycle counts between wraps and the wall-clock spacing of ticks are checked separately.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  localparam int unsigned TB_W = 16;

  typedef logic [TB_W-1:0] tb_word_t;

  typedef struct packed {
    tb_word_t period;
    tb_word_t prescale;
  } tb_cfg_t;

  // A prescale of zero behaves as a divide-by-one.
  function automatic tb_word_t eff_div(tb_word_t p);
    return (p == '0) ? tb_word_t'(1) : p;
  endfunction

  // The count is at its terminal value (period zero is always terminal).
  function automatic logic is_last(tb_word_t cnt, tb_word_t per);
    return (per == '0) || (cnt >= per - tb_word_t'(1));
  endfunction

  function automatic tb_word_t bump(tb_word_t v);
    return v + tb_word_t'(1);
  endfunction

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
  import tbase_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tb_word_t div,
  output logic     tick
);

  tb_word_t phase;
  tb_word_t lim;

  assign lim  = eff_div(div) - tb_word_t'(1);
  assign tick = (phase >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= bump(phase);
  end

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  tb_word_t per,
  output tb_word_t cnt,
  output logic     last
);

  assign last = is_last(cnt, per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= last ? '0 : bump(cnt);
  end

endmodule

// File: rtl/tbase_shadow.sv
module tbase_shadow
  import tbase_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  tb_cfg_t nxt,
  output tb_cfg_t cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= nxt;
  end

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TB_W-1:0] cfg_period,
  input  logic [TB_W-1:0] cfg_prescale,
  output logic [TB_W-1:0] timer,
  output logic           tick_en,
  output logic [TB_W-1:0] period_q,
  output logic [TB_W-1:0] prescale_q
);

  tb_cfg_t  cfg_in;
  tb_cfg_t  cfg_cur;
  tb_word_t tmr_w;
  logic     tick_w;
  logic     last_w;
  logic     load_w;

  assign cfg_in.period   = cfg_period;
  assign cfg_in.prescale = cfg_prescale;

  tbase_prescaler u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (cfg_cur.prescale),
    .tick (tick_w)
  );

  tbase_counter u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w),
    .per  (cfg_cur.period),
    .cnt  (tmr_w),
    .last (last_w)
  );

  // Wrap point: a tick while the timer sits on its terminal value.
  assign load_w = tick_w & last_w;

  tbase_shadow u_shd (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_w),
    .nxt  (cfg_in),
    .cur  (cfg_cur)
  );

  assign timer      = tmr_w;
  assign tick_en    = tick_w;
  assign period_q   = cfg_cur.period;
  assign prescale_q = cfg_cur.prescale;

endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk
  import tbase_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input tb_word_t cfg_period,
  input tb_word_t cfg_prescale,
  input tb_word_t timer,
  input logic     tick_en,
  input tb_word_t period_q,
  input tb_word_t prescale_q,
  input logic     at_last
);

  tb_word_t gap;
  logic     seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick_en) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + tb_word_t'(1);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (timer == '0 && period_q == '0 && prescale_q == '0));

  // R2
  unity_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale_q <= tb_word_t'(1)) |-> tick_en);

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && seen) |-> (gap == eff_div(prescale_q) - tb_word_t'(1)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(timer));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !at_last) |=> (timer == $past(timer) + tb_word_t'(1)));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && at_last) |=> (timer == '0));

  // R5
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q != '0) |-> (timer < period_q));

  // R6
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0) |-> (timer == '0));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_en && at_last) |=> ($stable(period_q) && $stable(prescale_q)));

  // R7
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && at_last) |=>
      (period_q == $past(cfg_period) && prescale_q == $past(cfg_prescale)));

endmodule

bind tbase_timer tbase_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_period  (cfg_period),
  .cfg_prescale(cfg_prescale),
  .timer       (timer),
  .tick_en     (tick_en),
  .period_q    (period_q),
  .prescale_q  (prescale_q),
  .at_last     (last_w)
);

// File: tb/tbase_timer_tb.sv
`timescale 1ns/1ps
module tbase_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_period;
  logic [15:0] cfg_prescale;
  logic [15:0] timer;
  logic        tick_en;
  logic [15:0] period_q;
  logic [15:0] prescale_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tbase_timer u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_period  (cfg_period),
    .cfg_prescale(cfg_prescale),
    .timer       (timer),
    .tick_en     (tick_en),
    .period_q    (period_q),
    .prescale_q  (prescale_q)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: integers for phase, timer and settings in force.
  int m_tmr, m_phase, m_per, m_psc;

  always @(posedge clk or negedge rst_n) begin
    int  e;
    bit  t, l;
    if (!rst_n) begin
      m_tmr = 0; m_phase = 0; m_per = 0; m_psc = 0;
    end else begin
      e = (m_psc == 0) ? 1 : m_psc;
      t = (m_phase == e - 1);
      l = (m_per == 0) || (m_tmr == m_per - 1);
      if (t) begin
        m_phase = 0;
        if (l) begin
          m_tmr = 0;
          m_per = int'(cfg_period);
          m_psc = int'(cfg_prescale);
        end else begin
          m_tmr = m_tmr + 1;
        end
      end else begin
        m_phase = m_phase + 1;
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    int  e;
    bit  et;
    if (rst_n && !done) begin
      e  = (m_psc == 0) ? 1 : m_psc;
      et = (m_phase == e - 1);
      chk(int'(timer) == m_tmr, "R4", "timer vs model", timer, m_tmr);
      chk(tick_en == et, (m_psc <= 1) ? "R2" : "R3", "tick_en vs model",
          tick_en, et);
      chk(int'(period_q) == m_per && int'(prescale_q) == m_psc, "R7",
          "captured settings vs model", {period_q, prescale_q},
          {m_per[15:0], m_psc[15:0]});
    end
  end

  task automatic wait_load(input int per, input int lim, input string tag);
    int k = 0;
    while (int'(period_q) != per && k < lim) begin
      @(negedge clk);
      k++;
    end
    chk(int'(period_q) == per, tag, "new period taken at wrap", period_q, per);
  endtask

  task automatic tick_spacing(input int psc, input string tag);
    time t0, t1;
    do @(negedge clk); while (!tick_en);
    t0 = $time;
    do @(negedge clk); while (!tick_en);
    t1 = $time;
    chk((t1 - t0) == time'(4 * psc), tag, "tick spacing in ns",
        longint'(t1 - t0), 4 * psc);
  endtask

  initial begin
    int cnt, mx, prev;
    cfg_period   = 16'd5;
    cfg_prescale = 16'd3;
    rst_n        = 1'b1;
    #1 rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(timer == 16'd0, "R1", "timer in reset", timer, 0);
    chk(period_q == 16'd0 && prescale_q == 16'd0, "R1",
        "captured settings in reset", {period_q, prescale_q}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: first edge after release captures the inputs
    chk(period_q == 16'd5 && prescale_q == 16'd3 && timer == 16'd0, "R8",
        "first edge capture", {period_q, prescale_q}, {16'd5, 16'd3});

    // R7: mid-period change must wait for the wrap
    repeat (7) @(negedge clk);
    cfg_period   = 16'd7;
    cfg_prescale = 16'd2;
    @(negedge clk);
    chk(period_q == 16'd5 && prescale_q == 16'd3, "R7",
        "inputs ignored mid period", {period_q, prescale_q}, {16'd5, 16'd3});
    wait_load(7, 40, "R7");
    chk(prescale_q == 16'd2 && timer == 16'd0, "R7",
        "prescale taken with period, timer at 0", {prescale_q, timer},
        {16'd2, 16'd0});
    tick_spacing(2, "R3");

    // R2: prescale 0 ticks every cycle
    cfg_period   = 16'd4;
    cfg_prescale = 16'd0;
    wait_load(4, 40, "R2");
    cnt = 0;
    repeat (12) begin
      @(negedge clk);
      if (tick_en) cnt++;
    end
    chk(cnt == 12, "R2", "ticks in 12 cycles at prescale 0", cnt, 12);

    // R6: period 0 holds the timer
    cfg_period   = 16'd0;
    cfg_prescale = 16'd1;
    wait_load(0, 20, "R6");
    cnt = 0;
    repeat (20) begin
      @(negedge clk);
      if (timer != 16'd0) cnt++;
    end
    chk(cnt == 0, "R6", "nonzero timer samples with period 0", cnt, 0);
    cfg_period   = 16'd3;
    cfg_prescale = 16'd3;
    @(negedge clk);
    chk(period_q == 16'd3 && prescale_q == 16'd3, "R6",
        "period 0 makes every tick a wrap", {period_q, prescale_q},
        {16'd3, 16'd3});
    tick_spacing(3, "R3");

    // R5: 20 kHz setting wraps every 12500 cycles
    cfg_period   = 16'd12500;
    cfg_prescale = 16'd1;
    wait_load(12500, 40, "R5");
    cnt  = 0;
    prev = int'(timer);
    repeat (25000) begin
      @(negedge clk);
      if (prev == 12499 && timer == 16'd0) cnt++;
      prev = int'(timer);
    end
    chk(cnt == 2, "R5", "wraps in 25000 cycles at period 12500", cnt, 2);

    // R9: full-range period
    cfg_period   = 16'd65535;
    cfg_prescale = 16'd1;
    wait_load(65535, 13000, "R9");
    cfg_period   = 16'd62500;
    cfg_prescale = 16'd2;
    mx = 0;
    repeat (65535) begin
      @(negedge clk);
      if (int'(timer) > mx) mx = int'(timer);
    end
    chk(mx == 65534, "R9", "largest timer value at period 65535", mx, 65534);
    chk(period_q == 16'd62500 && timer == 16'd0, "R9",
        "wrap after 65535 and capture", {period_q, timer}, {16'd62500, 16'd0});
    tick_spacing(2, "R3");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule